// File: doc/BRIEF.md
# Oscillator Trim Search Controller

This block finds an 8-bit trim code for an on-chip clock oscillator. It compares the oscillator against a precision reference pulse that has a known high time. For each candidate code it waits for a fresh rising edge of the reference. It then counts how long the pulse stays high, adding one tick for every four bus clocks, and compares that tick count with a fixed target of 500.

The sense of the trim is inverted: a larger code slows the oscillator. When the count is below target the bus clock is too slow, so the code is lowered. When the count is above target the code is raised. Each step is half the size of the one before. The search starts at the midpoint code. It stops early on an exact match, or after the eighth adjustment.

When the search stops, the block pulses a store strobe so that surrounding logic can copy the code into non-volatile storage. The code is then held for normal operation.

Top module: `osc_trim_sar`

## Requirements
- R1: After reset the trim code is 0x80, and busy, done and the store strobe are all 0.
- R2: A start request seen while the block is idle sets busy and reloads the trim code to 0x80 on the next clock, with iteration index n = 1. A start request seen while busy has no effect on the code or on busy.
- R3: The reference passes through a two-stage synchronizer. A measurement starts only at a rising edge of the synchronized reference that arrives after the last load or adjustment, so a pulse already high at that point is ignored. The measurement counts floor(H/4) ticks, where H is the number of clocks that the synchronized reference stays high.
- R4: If the tick count is below 500 (too slow), the code is lowered by 128 >> n.
- R5: If the tick count is above 500 (too fast), the code is raised by 128 >> n.
- R6: A tick count of exactly 500 ends the search at once, with the code unchanged.
- R7: After each adjustment n increases by one. The search ends after the adjustment made at n = 8, where the step is zero and the code is left as it was.
- R8: When the search ends, done and the store strobe are both high for exactly one clock, and busy is low in that same clock.
- R9: The tick counter is 12 bits wide and holds at 4095 instead of wrapping. A held count of 4095 is treated as too slow.
- R10: A single adjustment never moves the code by more than 64. While the block is idle and no start is requested, the code does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Precision reference pulse, asynchronous to clk |
| startReq | input | 1 | Request to begin a trim search |
| trimCode | output | 8 | Current trim code driven to the oscillator |
| busy | output | 1 | High while a search is in progress |
| done | output | 1 | One-clock pulse when the search ends |
| storeStrobe | output | 1 | One-clock pulse telling surrounding logic to store trimCode |

## Verification
The two ways the search can end, an exact count match and reaching n = 8, can happen in the same decision cycle. When they do, the controller must produce a single done pulse and must not apply an adjustment. The bench provokes this by placing the oscillator's ideal code at 0xFF, which the search first reaches at the very last measurement. It also places the ideal code at 0x80 with a one-clock shortfall in the pulse, so the search never matches and ends only through the iteration limit. In both cases the bench judges the final code, and checks that done and the store strobe appear together for one clock while busy is low.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic load;     // reload midpoint code and clear measurement
    logic clear;    // clear measurement counters
    logic countEn;  // reference high: advance prescaler
    logic adjust;   // apply one search step
    logic stepUp;   // direction of the step: 1 raises the code
  } dp_cmd_t;

  // Status from the datapath to the controller
  typedef struct packed {
    logic rise;     // synchronized reference rising edge
    logic refHigh;  // synchronized reference level
    logic tooSlow;  // count below target or saturated
    logic match;    // count equals target exactly
  } dp_stat_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEASURE,
    ST_DECIDE,
    ST_FINISH
  } trim_state_t;

endpackage

// File: rtl/osc_trim_dp.sv
module osc_trim_dp import osc_trim_pkg::*; #(
  parameter int TRIM_W      = 8,
  parameter int CNT_W       = 12,
  parameter int PRESCALE    = 4,
  parameter int EXPECTED    = 500,
  parameter int SYNC_STAGES = 2,
  parameter int ITER_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  dp_cmd_t           cmd,
  input  logic [ITER_W-1:0] iter,
  output logic [TRIM_W-1:0] trimCode,
  output dp_stat_t          stat
);

  localparam logic [TRIM_W-1:0] MID_CODE = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [TRIM_W-1:0] MAX_STEP = MID_CODE >> 1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]  TARGET   = CNT_W'(EXPECTED);
  localparam int                PRE_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  // Reference synchronizer
  logic [SYNC_STAGES-1:0] syncChain;
  logic refSync;
  logic refPrev;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[0] <= 1'b0;
        else       syncChain[0] <= refIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[g] <= 1'b0;
        else       syncChain[g] <= syncChain[g-1];
      end
    end
  end

  assign refSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refPrev <= 1'b0;
    else       refPrev <= refSync;
  end

  // Prescaler: one tick per PRESCALE enabled clocks
  logic tick;

  if (PRESCALE > 1) begin : g_pre
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    logic [PRE_W-1:0] preCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                    preCnt <= '0;
      else if (cmd.load || cmd.clear) preCnt <= '0;
      else if (cmd.countEn)         preCnt <= (preCnt == PRE_LAST) ? '0 : preCnt + 1'b1;
    end

    assign tick = cmd.countEn && (preCnt == PRE_LAST);
  end else begin : g_nopre
    assign tick = cmd.countEn;
  end

  // Saturating tick counter
  logic [CNT_W-1:0] tickCount;
  logic             saturated;

  assign saturated = (tickCount == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      tickCount <= '0;
    else if (cmd.load || cmd.clear) tickCount <= '0;
    else if (tick && !saturated)    tickCount <= tickCount + 1'b1;
  end

  // Trim code register with halving step
  logic [TRIM_W-1:0] stepVal;
  logic [TRIM_W-1:0] trimReg;

  assign stepVal = MID_CODE >> iter;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           trimReg <= MID_CODE;
    else if (cmd.load)   trimReg <= MID_CODE;
    else if (cmd.adjust) trimReg <= cmd.stepUp ? (trimReg + stepVal) : (trimReg - stepVal);
  end

  assign trimCode     = trimReg;
  assign stat.rise    = refSync && !refPrev;
  assign stat.refHigh = refSync;
  assign stat.tooSlow = saturated || (tickCount < TARGET);
  assign stat.match   = !saturated && (tickCount == TARGET);

  // Assertions
  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.countEn && !cmd.clear && !cmd.load && saturated) |=> (tickCount == CNT_MAX))
    else $error("tick counter left saturation");

  assert_step_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.adjust && !cmd.stepUp && !cmd.load) |=> (trimReg <= $past(trimReg)))
    else $error("downward step raised the code");

  assert_step_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.adjust && cmd.stepUp && !cmd.load) |=> (trimReg >= $past(trimReg)))
    else $error("upward step lowered the code");

  assert_step_bound_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.adjust && !cmd.load) |=>
      (((trimReg >= $past(trimReg)) ? (trimReg - $past(trimReg))
                                    : ($past(trimReg) - trimReg)) <= MAX_STEP))
    else $error("adjustment larger than the first step");

endmodule

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl import osc_trim_pkg::*; #(
  parameter int ITERS  = 8,
  parameter int ITER_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  dp_stat_t          stat,
  output dp_cmd_t           cmd,
  output logic [ITER_W-1:0] iter,
  output logic              busy,
  output logic              done,
  output logic              storeStrobe
);

  localparam logic [ITER_W-1:0] ITER_FIRST = ITER_W'(1);
  localparam logic [ITER_W-1:0] ITER_LAST  = ITER_W'(ITERS);

  trim_state_t       state, stateNext;
  logic [ITER_W-1:0] iterNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      iter  <= '0;
    end else begin
      state <= stateNext;
      iter  <= iterNext;
    end
  end

  always_comb begin
    cmd       = '0;
    stateNext = state;
    iterNext  = iter;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          cmd.load  = 1'b1;
          iterNext  = ITER_FIRST;
          stateNext = ST_ARM;
        end
      end
      ST_ARM: begin
        if (stat.rise) begin
          cmd.countEn = 1'b1;
          stateNext   = ST_MEASURE;
        end else begin
          cmd.clear = 1'b1;
        end
      end
      ST_MEASURE: begin
        if (stat.refHigh) cmd.countEn = 1'b1;
        else              stateNext   = ST_DECIDE;
      end
      ST_DECIDE: begin
        if (stat.match) begin
          stateNext = ST_FINISH;
        end else begin
          cmd.adjust = 1'b1;
          cmd.stepUp = !stat.tooSlow;
          iterNext   = iter + 1'b1;
          stateNext  = (iter >= ITER_LAST) ? ST_FINISH : ST_ARM;
        end
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  assign busy        = (state == ST_ARM) || (state == ST_MEASURE) || (state == ST_DECIDE);
  assign done        = (state == ST_FINISH);
  assign storeStrobe = (state == ST_FINISH);

  // Assertions
  assert_iter_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (iter >= ITER_FIRST && iter <= ITER_LAST))
    else $error("iteration index out of range while busy");

  assert_match_ends_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECIDE && stat.match) |=> (done && $stable(iter)))
    else $error("exact match did not end the search");

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy))
    else $error("done held longer than one clock");

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && state != ST_DECIDE) |=> $stable(iter))
    else $error("start request disturbed a running search");

endmodule

// File: rtl/osc_trim_sar.sv
module osc_trim_sar import osc_trim_pkg::*; #(
  parameter int TRIM_W      = 8,
  parameter int CNT_W       = 12,
  parameter int PRESCALE    = 4,
  parameter int EXPECTED    = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refIn,
  input  logic              startReq,
  output logic [TRIM_W-1:0] trimCode,
  output logic              busy,
  output logic              done,
  output logic              storeStrobe
);

  localparam int ITERS  = TRIM_W;
  localparam int ITER_W = $clog2(ITERS + 2);
  localparam logic [TRIM_W-1:0] MID_CODE = TRIM_W'(1) << (TRIM_W - 1);

  dp_cmd_t           cmd;
  dp_stat_t          stat;
  logic [ITER_W-1:0] iter;

  osc_trim_ctrl #(
    .ITERS (ITERS),
    .ITER_W(ITER_W)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .stat       (stat),
    .cmd        (cmd),
    .iter       (iter),
    .busy       (busy),
    .done       (done),
    .storeStrobe(storeStrobe)
  );

  osc_trim_dp #(
    .TRIM_W     (TRIM_W),
    .CNT_W      (CNT_W),
    .PRESCALE   (PRESCALE),
    .EXPECTED   (EXPECTED),
    .SYNC_STAGES(SYNC_STAGES),
    .ITER_W     (ITER_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .refIn   (refIn),
    .cmd     (cmd),
    .iter    (iter),
    .trimCode(trimCode),
    .stat    (stat)
  );

  assert_start_mid_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (trimCode == MID_CODE))
    else $error("search did not begin at the midpoint code");

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> $stable(trimCode))
    else $error("trim code moved while idle");

  assert_strobe_pair_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(storeStrobe) |-> (done && !busy))
    else $error("store strobe without done");

endmodule

// File: tb/test_osc_trim_sar.sv
`timescale 1ns/1ps
module test_osc_trim_sar;

  typedef struct packed {
    logic [7:0]        tgt;
    logic signed [7:0] off;
    logic [7:0]        expCode;
  } row_t;

  // Oscillator: high time H = 2000 + 8*(tgt - code) + off clocks.
  localparam int NROWS = 6;
  localparam row_t ROWS [0:NROWS-1] = '{
    '{8'h80,  8'sd0, 8'h80},   // exact at n=1 (R6)
    '{8'h37,  8'sd0, 8'h37},   // mixed directions (R4, R5)
    '{8'hC9,  8'sd3, 8'hC9},   // floor of H/4 ignores 3 extra clocks (R3)
    '{8'hFF,  8'sd0, 8'hFF},   // match only at n=8 (R6 with R7)
    '{8'h80, -8'sd1, 8'h7F},   // never matches, ends by limit (R7)
    '{8'h00,  8'sd0, 8'h01}    // all downward, final step zero (R7)
  };
  localparam int LOW_CYC = 12;
  localparam int WD_LIMIT = 195000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refIn = 1'b0;
  logic startReq = 1'b0;
  logic [7:0] trimCode;
  logic busy, done, storeStrobe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int tgt = 128;
  int off = 0;
  bit satMode = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  osc_trim_sar i_osc_trim_sar (
    .clk(clk), .rstN(rstN), .refIn(refIn), .startReq(startReq),
    .trimCode(trimCode), .busy(busy), .done(done), .storeStrobe(storeStrobe)
  );

  function automatic int hiCycles(logic [7:0] code);
    int v;
    if (satMode && code >= 8'd100) return 16400;
    v = 2000 + 8 * (tgt - int'(code)) + off;
    if (v < 4) v = 4;
    return v;
  endfunction

  // Reference generator
  initial begin
    wait (rstN === 1'b1);
    forever begin
      refIn = 1'b0;
      repeat (LOW_CYC) @(negedge clk);
      refIn = 1'b1;
      repeat (hiCycles(trimCode)) @(negedge clk);
    end
  end

  task automatic checkEq(string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    checkEq("R2 busy after start", int'(busy), 1);
    checkEq("R2 code reloaded to midpoint", int'(trimCode), 128);
  endtask

  task automatic startAfterFall();
    @(negedge refIn);
    pulseStart();
  endtask

  task automatic finishCheck(int expCode, string tag);
    do @(negedge clk); while (done !== 1'b1);
    checkEq({tag, " final code"}, int'(trimCode), expCode);
    checkEq("R8 store strobe with done", int'(storeStrobe), 1);
    checkEq("R8 busy low at done", int'(busy), 0);
    @(negedge clk);
    checkEq("R8 done is one clock", int'(done), 0);
    checkEq("R8 store strobe is one clock", int'(storeStrobe), 0);
    repeat (3) @(negedge clk);
    checkEq("R10 code held while idle", int'(trimCode), expCode);
  endtask

  // Watchdog
  initial begin
    wait (cycles >= WD_LIMIT);
    checks++;
    errors++;
    $display("FAIL R8 watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 reset code", int'(trimCode), 128);
    checkEq("R1 reset busy", int'(busy), 0);
    checkEq("R1 reset done", int'(done), 0);
    checkEq("R1 reset store strobe", int'(storeStrobe), 0);

    // Table walk: R4 R5 R6 R7 and R3 floor behaviour
    for (int i = 0; i < NROWS; i++) begin
      tgt = int'(ROWS[i].tgt);
      off = int'(ROWS[i].off);
      satMode = 1'b0;
      startAfterFall();
      finishCheck(int'(ROWS[i].expCode), "R4/R5/R6/R7 table");
    end

    // R9: saturated count at code 128 must read as too slow (128 -> 64 -> 32 -> 48 -> 40)
    tgt = 40; off = 0; satMode = 1'b1;
    startAfterFall();
    finishCheck(40, "R9 saturation");
    satMode = 1'b0;

    // R3: start in the middle of a high pulse; that pulse must be ignored
    tgt = 128; off = 0;
    @(posedge refIn);
    repeat (600) @(negedge clk);
    pulseStart();
    finishCheck(128, "R3 partial pulse ignored");

    // R2: start while busy is ignored
    tgt = 8'h37; off = 0;
    startAfterFall();
    while (trimCode !== 8'd64) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    checkEq("R2 start while busy keeps code", int'(trimCode), 64);
    checkEq("R2 start while busy keeps busy", int'(busy), 1);
    finishCheck(8'h37, "R2 search after ignored start");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule